// File: doc/BRIEF.md
# Resizable Miss Status Register File

This block tracks the outstanding misses of a non-blocking level-one data cache. Each physical entry holds one block address, a fixed number of target slots, a valid flag and a usable flag. A miss request is matched against the live entries. A matching entry takes another target. Otherwise a free, usable entry is allocated. A response from the next memory level is looked up against every live entry, returns that entry's targets and frees it.

The number of usable entries can change while the block runs. A resize controller keeps the count at a power of two and marks the lowest entries of the file as usable. One command doubles the count and another halves it. When the count shrinks, entries that still hold misses lose their usable flag but stay live, so their responses still complete. The blocking output reflects a smaller count in the same cycle that the count changes.

Top module: `mshr_resize_file`

## Requirements
- R1: After reset the usable count equals ENTRIES, every bit of usable_mask is 1, no entry is live, and blocked is 0.
- R2: A grow pulse doubles the usable count and a shrink pulse halves it, visible from the next cycle. The count saturates at 1 and at ENTRIES. Both pulses in the same cycle leave it unchanged. usable_mask bit i is 1 exactly when i is less than the count.
- R3: A primary miss (no live entry has the same address) that is not blocked is acknowledged in the same cycle. It takes the lowest-index entry that is both free and usable, and miss_idx reports that index. The entry then holds the address with the request's target in slot 0 and a target count of 1.
- R4: blocked is 1 when no entry is free and usable together, or when the number of live entries is at least the usable count.
- R5: A primary miss while blocked is not acknowledged and changes no state.
- R6: A secondary miss (a live entry has the same address, whether usable or not) is acknowledged with that entry's index when its target count is below TGTS. The target goes to the next slot. With all TGTS slots filled, the miss is not acknowledged and nothing changes.
- R7: A response whose address matches a live entry, usable or not, drives rsp_hit, rsp_cnt and rsp_tgts in the same cycle. Slot j sits at bits j*TGT_W upward, and unfilled slots read 0. The entry is free from the next cycle.
- R8: A response that matches no live entry gives rsp_hit 0 and changes no state.
- R9: When a miss and a response fall in the same cycle, every miss decision uses the state before the response. A miss to the address being answered is not acknowledged. An entry freed by the response cannot be allocated before the next cycle.
- R10: Shrinking the usable count never drops a live entry or any of its stored targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grow | input | 1 | Double the usable count |
| shrink | input | 1 | Halve the usable count |
| miss_vld | input | 1 | Miss request present |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_tgt | input | TGT_W | Target information of the miss |
| miss_ack | output | 1 | Miss accepted this cycle |
| miss_idx | output | IDX_W | Entry used by the accepted miss |
| blocked | output | 1 | No room for a primary miss |
| rsp_vld | input | 1 | Memory response present |
| rsp_addr | input | ADDR_W | Block address of the response |
| rsp_hit | output | 1 | Response matched a live entry |
| rsp_cnt | output | TC_W | Number of stored targets returned |
| rsp_tgts | output | TGTS*TGT_W | Stored targets of the matched entry |
| usable_cnt | output | CNT_W | Current usable entry count |
| usable_mask | output | ENTRIES | Usable flag of each entry |

## Verification
The difficult overlap is a miss and a response in the same cycle, especially to the same block address or when the file is full. The random stimulus draws both from a small address pool and aims most responses at live entries, so these overlaps happen often. Directed cases also place a response to the block a miss targets in the same cycle, and fill the file before a response frees one entry. A bench model that decides from the state before the edge judges the acknowledge, the reported index and the returned targets, and a later response shows whether any target was lost.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  typedef enum logic [1:0] {
    RSZ_HOLD   = 2'd0,
    RSZ_GROW   = 2'd1,
    RSZ_SHRINK = 2'd2
  } rsz_cmd_e;
endpackage

// File: rtl/mrf_pick.sv
module mrf_pick #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mrf_mask_ctrl.sv
module mrf_mask_ctrl
  import mrf_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int EXP_W  = $clog2(IDX_W + 1)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               grow,
  input  logic               shrink,
  output logic [CNT_W-1:0]   usable_cnt,
  output logic [ENTRIES-1:0] usable_mask
);
  localparam logic [EXP_W-1:0] MAX_EXP = EXP_W'(IDX_W);

  rsz_cmd_e         cmd;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic             exp_en;

  always_comb begin
    unique case ({grow, shrink})
      2'b10:   cmd = RSZ_GROW;
      2'b01:   cmd = RSZ_SHRINK;
      default: cmd = RSZ_HOLD;
    endcase
  end

  always_comb begin
    exp_d  = exp_q;
    exp_en = 1'b0;
    if (cmd == RSZ_GROW && exp_q != MAX_EXP) begin
      exp_d  = exp_q + 1'b1;
      exp_en = 1'b1;
    end else if (cmd == RSZ_SHRINK && exp_q != '0) begin
      exp_d  = exp_q - 1'b1;
      exp_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     exp_q <= MAX_EXP;
    else if (exp_en) exp_q <= exp_d;
  end

  assign usable_cnt = CNT_W'(1) << exp_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_mask
    assign usable_mask[i] = (CNT_W'(i) < usable_cnt);
  end

  AST_GROW_DOUBLES: assert property (@(posedge clk) disable iff (!rst_ni)
    (grow && !shrink && usable_cnt != CNT_W'(ENTRIES)) |=> (usable_cnt == ($past(usable_cnt) << 1))); // R2
  AST_SHRINK_HALVES: assert property (@(posedge clk) disable iff (!rst_ni)
    (shrink && !grow && usable_cnt != CNT_W'(1)) |=> (usable_cnt == ($past(usable_cnt) >> 1))); // R2
  AST_COUNT_POW2: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones(usable_cnt) == 1); // R2
endmodule

// File: rtl/mrf_entry.sv
module mrf_entry #(
  parameter int ADDR_W = 12,
  parameter int TGT_W  = 8,
  parameter int TGTS   = 4,
  localparam int TC_W  = $clog2(TGTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  alloc,
  input  logic                  append,
  input  logic                  release_i,
  input  logic [ADDR_W-1:0]     miss_addr,
  input  logic [TGT_W-1:0]      miss_tgt,
  input  logic [ADDR_W-1:0]     rsp_addr,
  output logic                  valid,
  output logic                  miss_match,
  output logic                  rsp_match,
  output logic [TGTS*TGT_W-1:0] tgts,
  output logic [TC_W-1:0]       tcnt
);
  logic                           valid_q, valid_d;
  logic [ADDR_W-1:0]              addr_q, addr_d;
  logic [TGTS-1:0][TGT_W-1:0]     tgt_q, tgt_d;
  logic [TC_W-1:0]                cnt_q, cnt_d;
  logic                           upd_en;

  assign upd_en = alloc | append | release_i;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q;
    if (alloc) begin
      valid_d  = 1'b1;
      addr_d   = miss_addr;
      tgt_d    = '0;
      tgt_d[0] = miss_tgt;
      cnt_d    = TC_W'(1);
    end else if (append) begin
      for (int j = 0; j < TGTS; j++) begin
        if (TC_W'(j) == cnt_q) tgt_d[j] = miss_tgt;
      end
      cnt_d = cnt_q + 1'b1;
    end
    if (release_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      tgt_q   <= tgt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign valid      = valid_q;
  assign miss_match = valid_q && (addr_q == miss_addr);
  assign rsp_match  = valid_q && (addr_q == rsp_addr);
  assign tgts       = tgt_q;
  assign tcnt       = cnt_q;

  AST_APPEND_ROOM: assert property (@(posedge clk) disable iff (!rst_ni)
    append |-> (valid_q && cnt_q < TC_W'(TGTS))); // R6
  AST_ALLOC_FREE_ONLY: assert property (@(posedge clk) disable iff (!rst_ni)
    alloc |-> !valid_q); // R3
  AST_NO_APPEND_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_ni)
    !(append && release_i)); // R9
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    release_i |=> !valid_q); // R7
endmodule

// File: rtl/mshr_resize_file.sv
module mshr_resize_file #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 12,
  parameter int TGT_W   = 8,
  parameter int TGTS    = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int TC_W   = $clog2(TGTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grow,
  input  logic                  shrink,
  input  logic                  miss_vld,
  input  logic [ADDR_W-1:0]     miss_addr,
  input  logic [TGT_W-1:0]      miss_tgt,
  output logic                  miss_ack,
  output logic [IDX_W-1:0]      miss_idx,
  output logic                  blocked,
  input  logic                  rsp_vld,
  input  logic [ADDR_W-1:0]     rsp_addr,
  output logic                  rsp_hit,
  output logic [TC_W-1:0]       rsp_cnt,
  output logic [TGTS*TGT_W-1:0] rsp_tgts,
  output logic [CNT_W-1:0]      usable_cnt,
  output logic [ENTRIES-1:0]    usable_mask
);
  // reset: asynchronous assertion, synchronous release
  logic rst_q1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_ni <= rst_q1;
    end
  end

  logic [ENTRIES-1:0]                 ent_valid, ent_mmatch, ent_rmatch;
  logic [ENTRIES-1:0]                 ent_alloc, ent_append, ent_release;
  logic [ENTRIES-1:0][TGTS*TGT_W-1:0] ent_tgts;
  logic [ENTRIES-1:0][TC_W-1:0]       ent_cnt;

  mrf_mask_ctrl #(.ENTRIES(ENTRIES)) u_mask (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .grow       (grow),
    .shrink     (shrink),
    .usable_cnt (usable_cnt),
    .usable_mask(usable_mask)
  );

  logic             free_found, hit_any, rsp_any;
  logic [IDX_W-1:0] free_idx, hit_idx, rsp_idx;
  logic [ENTRIES-1:0] free_usable;

  assign free_usable = ~ent_valid & usable_mask;

  mrf_pick #(.N(ENTRIES)) u_pick_free (.req(free_usable), .found(free_found), .idx(free_idx));
  mrf_pick #(.N(ENTRIES)) u_pick_hit  (.req(ent_mmatch),  .found(hit_any),    .idx(hit_idx));
  mrf_pick #(.N(ENTRIES)) u_pick_rsp  (.req(ent_rmatch),  .found(rsp_any),    .idx(rsp_idx));

  logic [CNT_W-1:0] live_cnt;
  always_comb begin
    live_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) live_cnt = live_cnt + CNT_W'(ent_valid[i]);
  end

  logic miss_hit, same_blk, room;
  assign blocked  = !free_found || (live_cnt >= usable_cnt);
  assign miss_hit = miss_vld && hit_any;
  assign rsp_hit  = rsp_vld && rsp_any;
  assign same_blk = miss_hit && rsp_hit && (rsp_idx == hit_idx);
  assign room     = ent_cnt[hit_idx] < TC_W'(TGTS);

  always_comb begin
    miss_ack = 1'b0;
    if (miss_vld) begin
      if (hit_any) miss_ack = room && !same_blk;
      else         miss_ack = !blocked;
    end
  end

  assign miss_idx = hit_any ? hit_idx : free_idx;
  assign rsp_cnt  = rsp_hit ? ent_cnt[rsp_idx]  : '0;
  assign rsp_tgts = rsp_hit ? ent_tgts[rsp_idx] : '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign ent_alloc[i]   = miss_ack && !hit_any && (free_idx == IDX_W'(i));
    assign ent_append[i]  = miss_ack &&  hit_any && (hit_idx  == IDX_W'(i));
    assign ent_release[i] = rsp_hit && (rsp_idx == IDX_W'(i));

    mrf_entry #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .TGTS(TGTS)) u_ent (
      .clk       (clk),
      .rst_ni    (rst_ni),
      .alloc     (ent_alloc[i]),
      .append    (ent_append[i]),
      .release_i (ent_release[i]),
      .miss_addr (miss_addr),
      .miss_tgt  (miss_tgt),
      .rsp_addr  (rsp_addr),
      .valid     (ent_valid[i]),
      .miss_match(ent_mmatch[i]),
      .rsp_match (ent_rmatch[i]),
      .tgts      (ent_tgts[i]),
      .tcnt      (ent_cnt[i])
    );
  end

  AST_ALLOC_IN_USABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (miss_ack && !hit_any) |-> usable_mask[miss_idx]); // R3
  AST_NO_ACK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
    (miss_vld && !hit_any && blocked) |-> !miss_ack); // R5
  AST_RSP_FREES: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_hit |=> (live_cnt <= $past(live_cnt))); // R7
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(ent_mmatch)); // R6
  AST_SHRINK_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rsp_hit) |=> (live_cnt >= $past(live_cnt))); // R10
endmodule

// File: tb/mshr_resize_file_tb.sv
module mshr_resize_file_tb;
  localparam int ENTRIES = 8;
  localparam int ADDR_W  = 12;
  localparam int TGT_W   = 8;
  localparam int TGTS    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        grow, shrink, miss_vld, rsp_vld;
  logic [11:0] miss_addr, rsp_addr;
  logic [7:0]  miss_tgt;
  logic        miss_ack, blocked, rsp_hit;
  logic [2:0]  miss_idx, rsp_cnt;
  logic [31:0] rsp_tgts;
  logic [3:0]  usable_cnt;
  logic [7:0]  usable_mask;

  always #4 clk = ~clk; // 125 MHz

  mshr_resize_file #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TGT_W(TGT_W), .TGTS(TGTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .grow(grow), .shrink(shrink),
    .miss_vld(miss_vld), .miss_addr(miss_addr), .miss_tgt(miss_tgt),
    .miss_ack(miss_ack), .miss_idx(miss_idx), .blocked(blocked),
    .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
    .rsp_cnt(rsp_cnt), .rsp_tgts(rsp_tgts),
    .usable_cnt(usable_cnt), .usable_mask(usable_mask)
  );

  int checks = 0;
  int failures = 0;

  // bench model
  bit         mv [8];
  logic [11:0] ma [8];
  logic [7:0]  mt [8][4];
  int          mc [8];
  int          mn;
  string       rsp_tag = "";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] pool(int k);
    return 12'h100 + 12'(k * 16);
  endfunction

  task automatic step(input bit mvi, input logic [11:0] mai, input logic [7:0] mti,
                      input bit rvi, input logic [11:0] rai, input bit g, input bit s);
    int hit, fr, vc, rh;
    bit eblk, conf, eack;
    string tag;
    logic [31:0] et;
    @(negedge clk);
    miss_vld = mvi; miss_addr = mai; miss_tgt = mti;
    rsp_vld = rvi; rsp_addr = rai; grow = g; shrink = s;
    #1;
    hit = -1; fr = -1; rh = -1; vc = 0;
    for (int i = 0; i < 8; i++) begin
      if (mv[i]) vc++;
      if (mv[i] && ma[i] == mai) hit = i;
      if (rvi && mv[i] && ma[i] == rai) rh = i;
    end
    for (int i = 7; i >= 0; i--) if (i < mn && !mv[i]) fr = i;
    eblk = (fr < 0) || (vc >= mn);
    conf = mvi && hit >= 0 && rh == hit;
    eack = mvi && ((hit >= 0) ? (mc[hit] < TGTS && !conf) : !eblk);
    tag = conf ? "R9" : (hit >= 0) ? "R6" : eblk ? "R5" : "R3";
    chk("R4", "blocked", 64'(blocked), 64'(eblk));
    if (mvi) chk(tag, "miss_ack", 64'(miss_ack), 64'(eack));
    if (eack) chk(tag, "miss_idx", 64'(miss_idx), 64'((hit >= 0) ? hit : fr));
    chk((rh >= 0) ? "R7" : "R8", "rsp_hit", 64'(rsp_hit), 64'(rh >= 0));
    if (rh >= 0) begin
      et = '0;
      for (int j = 0; j < 4; j++) if (j < mc[rh]) et[j*8 +: 8] = mt[rh][j];
      chk((rsp_tag != "") ? rsp_tag : "R7", "rsp_cnt", 64'(rsp_cnt), 64'(mc[rh]));
      chk((rsp_tag != "") ? rsp_tag : "R7", "rsp_tgts", 64'(rsp_tgts), 64'(et));
    end
    chk("R2", "usable_cnt", 64'(usable_cnt), 64'(mn));
    chk("R2", "usable_mask", 64'(usable_mask), 64'((1 << mn) - 1));
    @(posedge clk);
    #1;
    if (eack) begin
      if (hit >= 0) begin
        mt[hit][mc[hit]] = mti;
        mc[hit]++;
      end else begin
        mv[fr] = 1'b1; ma[fr] = mai; mc[fr] = 1;
        for (int j = 0; j < 4; j++) mt[fr][j] = '0;
        mt[fr][0] = mti;
      end
    end
    if (rh >= 0) mv[rh] = 1'b0;
    if (g && !s && mn < 8) mn = mn * 2;
    else if (s && !g && mn > 1) mn = mn / 2;
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k, pick;
    bit mvr, rvr, gr, sr;
    logic [11:0] ra;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mc[i] = 0; ma[i] = '0; end
    mn = 8;
    rst_n = 1'b0; grow = 0; shrink = 0; miss_vld = 0; rsp_vld = 0;
    miss_addr = '0; rsp_addr = '0; miss_tgt = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 reset state
    @(negedge clk);
    chk("R1", "usable_cnt", 64'(usable_cnt), 64'd8);
    chk("R1", "usable_mask", 64'(usable_mask), 64'hff);
    chk("R1", "blocked", 64'(blocked), 64'd0);
    idle();

    // fill all entries, lowest index first (R3), then blocked (R4, R5)
    for (int i = 0; i < 8; i++) step(1, pool(i), 8'(8'h10 + i), 0, '0, 0, 0);
    step(1, pool(9), 8'h99, 0, '0, 0, 0);
    // fill targets of entry 5 (R6), one more is refused
    for (int j = 0; j < 4; j++) step(1, pool(5), 8'(8'hA0 + j), 0, '0, 0, 0);
    // shrink to 1 and past it (R2, R10)
    for (int j = 0; j < 4; j++) step(0, '0, '0, 0, '0, 0, 1);
    step(0, '0, '0, 0, '0, 1, 1);
    // response to a disabled entry returns intact targets (R10)
    rsp_tag = "R10";
    step(0, '0, '0, 1, pool(5), 0, 0);
    rsp_tag = "";
    // response and miss to the same block in one cycle (R9)
    step(1, pool(3), 8'h33, 1, pool(3), 0, 0);
    // grow past maximum (R2)
    for (int j = 0; j < 5; j++) step(0, '0, '0, 0, '0, 1, 0);
    // free entry 0 while a primary miss arrives: not reusable yet (R9)
    step(1, pool(3), 8'h44, 1, pool(0), 0, 0);
    step(1, pool(8), 8'h45, 0, '0, 0, 0);
    // response with no match (R8)
    step(0, '0, '0, 1, 12'hFFF, 0, 0);
    // drain
    for (int i = 0; i < 10; i++) step(0, '0, '0, 1, pool(i), 0, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      mvr = ($urandom % 100) < 60;
      rvr = ($urandom % 100) < 45;
      gr  = ($urandom % 100) < 4;
      sr  = ($urandom % 100) < 4;
      k = $urandom % 12;
      ra = pool($urandom % 12);
      if (rvr && ($urandom % 100) < 75) begin
        pick = $urandom % 8;
        if (mv[pick]) ra = ma[pick];
      end
      step(mvr, pool(k), 8'($urandom), rvr, ra, gr, sr);
    end
    idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule